// File: doc/BRIEF.md
# Staggered Lane Gate Chain

This block drives a row of lane gates that release data into a systolic array along a diagonal. A single external start pulse opens lane 0. The same start, together with the window length that was sampled with it, then moves down a one-register-per-lane delay line. As a result, lane k opens exactly one clock after lane k-1.

While a lane's gate is open, the lane does three things:
- it forwards its input word;
- it raises valid;
- it raises a pop strobe to the FIFO that feeds it.

When the gate is closed, the lane outputs zero, holds valid low and does not pop. Each gate stays open for the number of cycles that was on `openCycles` when the external start was sampled.

The same block fits in two places. On the input side it skews operand rows into the array. On the output side, with its own start, it re-aligns the result stream.

Top module: `gate_chain`

## Requirements
- R1: While `rstN` is low, every lane has `laneValid`=0, `lanePop`=0 and `laneDataOut`=0.
- R2: When `startPulse` is high at a rising edge with `openCycles`=N>0, lane 0 is open for exactly the N cycles that follow that edge.
- R3: Lane k (k≥1) receives the start, and the window length, of lane k-1 delayed by exactly one clock.
- R4: While a lane is open, `laneValid[k]`=1, `lanePop[k]`=1 and `laneDataOut[k]` equals `laneDataIn[k]` in the same cycle.
- R5: While a lane is closed, `laneValid[k]`=0, `lanePop[k]`=0 and `laneDataOut[k]`=0.
- R6: The window length is taken from `openCycles` only at the edge where `startPulse` is sampled high. Changes to `openCycles` at other times do not alter a window that has already been launched.
- R7: A start that reaches a lane while that lane is open reloads the lane's remaining count with the new length, counted from that edge.
- R8: A start sampled with `openCycles`=0 opens no lane and closes any lane it reaches.
- R9: Asserting `rstN` low in the middle of a window closes all lanes at once. It also discards starts that are still travelling down the delay line, so no lane opens after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Launches a window on lane 0 |
| openCycles | input | CNT_W | Window length, sampled with the start |
| laneDataIn | input | LANES×DATA_W | One word per lane from the upstream FIFOs |
| laneDataOut | output | LANES×DATA_W | Gated words toward the array |
| laneValid | output | LANES | Lane gate is open |
| lanePop | output | LANES | Pop strobe to each upstream FIFO |

## Verification
The bench goes after starts that overlap a running window. A design that ignored them would let the first window expire. A design that added the lengths would keep a lane open too long.

It changes `openCycles` one cycle after a start. A lane that samples the length at its own skewed start would show windows of different widths across the diagonal.

It issues a zero-length start. A design that treated it as a full wrap of the counter would hold the lanes open for 2^CNT_W cycles.

It pulses reset in the middle of a wave. A delay line that survives reset would open the trailing lanes after reset is released.

Long random runs at a high start rate compare every lane on every cycle. A skew off by one cycle, or a window one cycle long or short, shows up as a valid or data mismatch.

// File: rtl/gate_chain_pkg.sv
package gate_chain_pkg;
  // Strobe set handed from the lane control to the lane datapath.
  typedef struct packed {
    logic open;
  } lane_strobe_t;
endpackage

// File: rtl/gate_chain_ctrl.sv
module gate_chain_ctrl
  import gate_chain_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startPulse,
  input  logic [CNT_W-1:0]              openCycles,
  output lane_strobe_t [LANES-1:0]      strobes
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Start and length travel together so every lane of a wave gets the same length.
  logic [LANES-1:0]            laneGo;
  logic [LANES-1:0][CNT_W-1:0] laneLen;

  assign laneGo[0]  = startPulse;
  assign laneLen[0] = openCycles;

  generate
    for (genvar k = 1; k < LANES; k++) begin : g_skew
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          laneGo[k]  <= 1'b0;
          laneLen[k] <= '0;
        end else begin
          laneGo[k]  <= laneGo[k-1];
          laneLen[k] <= laneLen[k-1];
        end
      end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_count
      logic [CNT_W-1:0] remain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          remain <= '0;
        end else if (laneGo[k]) begin
          remain <= laneLen[k];
        end else if (remain != '0) begin
          remain <= remain - ONE;
        end
      end
      assign strobes[k].open = (remain != '0);
    end
  endgenerate
endmodule

// File: rtl/gate_chain_dp.sv
module gate_chain_dp
  import gate_chain_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 8
) (
  input  lane_strobe_t [LANES-1:0]      strobes,
  input  logic [LANES-1:0][DATA_W-1:0]  dataIn,
  output logic [LANES-1:0][DATA_W-1:0]  dataOut,
  output logic [LANES-1:0]              valid,
  output logic [LANES-1:0]              pop
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign dataOut[k] = strobes[k].open ? dataIn[k] : '0;
      assign valid[k]   = strobes[k].open;
      assign pop[k]     = strobes[k].open;
    end
  endgenerate
endmodule

// File: rtl/gate_chain.sv
module gate_chain
  import gate_chain_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startPulse,
  input  logic [CNT_W-1:0]              openCycles,
  input  logic [LANES-1:0][DATA_W-1:0]  laneDataIn,
  output logic [LANES-1:0][DATA_W-1:0]  laneDataOut,
  output logic [LANES-1:0]              laneValid,
  output logic [LANES-1:0]              lanePop
);
  lane_strobe_t [LANES-1:0] strobes;

  gate_chain_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .openCycles (openCycles),
    .strobes    (strobes)
  );

  gate_chain_dp #(.LANES(LANES), .DATA_W(DATA_W)) u_dp (
    .strobes (strobes),
    .dataIn  (laneDataIn),
    .dataOut (laneDataOut),
    .valid   (laneValid),
    .pop     (lanePop)
  );
endmodule

// File: rtl/gate_chain_chk.sv
module gate_chain_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          startPulse,
  input logic [CNT_W-1:0]              openCycles,
  input logic [LANES-1:0][DATA_W-1:0]  laneDataIn,
  input logic [LANES-1:0][DATA_W-1:0]  laneDataOut,
  input logic [LANES-1:0]              laneValid,
  input logic [LANES-1:0]              lanePop
);
  p_reset_closed_r1: assert property (@(posedge clk)
    !rstN |=> (laneValid == '0));

  p_lane0_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && openCycles != '0) |=> laneValid[0]);

  p_zero_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && openCycles == '0) |=> !laneValid[0]);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      p_open_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[k] |-> (lanePop[k] && laneDataOut[k] == laneDataIn[k]));

      p_closed_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
        !laneValid[k] |-> (!lanePop[k] && laneDataOut[k] == '0));
    end
    for (genvar k = 1; k < LANES; k++) begin : g_skew
      p_diag_skew_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(laneValid[k]) |-> $past(laneValid[k-1]));
    end
  endgenerate
endmodule

bind gate_chain gate_chain_chk #(.LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .openCycles  (openCycles),
  .laneDataIn  (laneDataIn),
  .laneDataOut (laneDataOut),
  .laneValid   (laneValid),
  .lanePop     (lanePop)
);

// File: tb/gate_chain_tb.sv
`timescale 1ns/1ps
module gate_chain_tb;
  localparam int LANES  = 4;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [CNT_W-1:0] openCycles = '0;
  logic [LANES-1:0][DATA_W-1:0] laneDataIn = '0;
  logic [LANES-1:0][DATA_W-1:0] laneDataOut;
  logic [LANES-1:0] laneValid;
  logic [LANES-1:0] lanePop;

  always #10 clk = ~clk;

  gate_chain #(.LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .openCycles(openCycles),
    .laneDataIn(laneDataIn), .laneDataOut(laneDataOut),
    .laneValid(laneValid), .lanePop(lanePop)
  );

  // Reference state built from the requirements.
  logic [LANES-1:0]            pipeGo;
  logic [LANES-1:0][CNT_W-1:0] pipeLen;
  logic [LANES-1:0][CNT_W-1:0] remain;
  int checks = 0;
  int fails = 0;
  string phaseTag = "R1";
  bit finished = 1'b0;

  function automatic void clearModel();
    pipeGo = '0; pipeLen = '0; remain = '0;
  endfunction

  // One rising edge of the reference: R2 (count), R3 (skew), R6 (length rides with start), R7 (reload).
  function automatic void advanceModel(logic s, logic [CNT_W-1:0] n);
    logic [LANES-1:0] go;
    logic [LANES-1:0][CNT_W-1:0] len;
    for (int k = 0; k < LANES; k++) begin
      go[k]  = (k == 0) ? s : pipeGo[k-1];
      len[k] = (k == 0) ? n : pipeLen[k-1];
    end
    for (int k = 0; k < LANES; k++) begin
      if (go[k]) remain[k] = len[k];
      else if (remain[k] != '0) remain[k] = remain[k] - CNT_W'(1);
    end
    pipeGo = go; pipeLen = len;
  endfunction

  task automatic compareLanes();
    for (int k = 0; k < LANES; k++) begin
      logic expOpen;
      logic [DATA_W-1:0] expData;
      expOpen = (remain[k] != '0);
      expData = expOpen ? laneDataIn[k] : '0;
      checks++;
      if (laneValid[k] !== expOpen || lanePop[k] !== expOpen || laneDataOut[k] !== expData) begin
        fails++;
        $display("FAIL %s/%s lane %0d: valid=%b pop=%b data=%h expected valid=%b pop=%b data=%h",
                 phaseTag, expOpen ? "R4" : "R5", k, laneValid[k], lanePop[k], laneDataOut[k],
                 expOpen, expOpen, expData);
      end
    end
  endtask

  task automatic step(input logic s, input logic [CNT_W-1:0] n, input logic r);
    @(posedge clk);
    if (!rstN) clearModel();
    else advanceModel(startPulse, openCycles);
    @(negedge clk);
    startPulse = s;
    openCycles = n;
    rstN = r;
    for (int k = 0; k < LANES; k++) laneDataIn[k] = DATA_W'($urandom);
    if (!r) clearModel();
    #1;
    compareLanes();
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, openCycles, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    clearModel();
    // R1: reset state
    phaseTag = "R1";
    step(1'b0, 8'd0, 1'b0);
    step(1'b0, 8'd0, 1'b0);
    step(1'b0, 8'd0, 1'b1);
    // R2 and R3: single window of three cycles crossing the diagonal
    phaseTag = "R2";
    step(1'b1, 8'd3, 1'b1);
    phaseTag = "R3";
    idle(10);
    // R8: zero-length start
    phaseTag = "R8";
    step(1'b1, 8'd0, 1'b1);
    idle(8);
    // R8: zero-length start arriving at open lanes closes them
    step(1'b1, 8'd6, 1'b1);
    step(1'b0, 8'd6, 1'b1);
    step(1'b1, 8'd0, 1'b1);
    idle(10);
    // R6: openCycles changes right after the start
    phaseTag = "R6";
    step(1'b1, 8'd4, 1'b1);
    step(1'b0, 8'd7, 1'b1);
    step(1'b0, 8'd1, 1'b1);
    idle(10);
    // R7: restart while open, shorter then longer
    phaseTag = "R7";
    step(1'b1, 8'd5, 1'b1);
    idle(2);
    step(1'b1, 8'd2, 1'b1);
    step(1'b0, 8'd2, 1'b1);
    step(1'b1, 8'd6, 1'b1);
    idle(12);
    // R9: reset in the middle of a wave
    phaseTag = "R9";
    step(1'b1, 8'd6, 1'b1);
    idle(1);
    step(1'b0, 8'd6, 1'b0);
    step(1'b0, 8'd6, 1'b0);
    step(1'b0, 8'd6, 1'b1);
    idle(10);
    // R3/R7: random starts and lengths
    phaseTag = "R3";
    for (int i = 0; i < 2000; i++) begin
      logic s;
      logic [CNT_W-1:0] n;
      s = ($urandom_range(0, 4) == 0);
      n = CNT_W'($urandom_range(0, 7));
      step(s, n, 1'b1);
    end
    phaseTag = "R2";
    idle(12);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule